// File: doc/BRIEF.md
# Interrupt Status and Watchdog Controller

This block sits beside a timekeeping core and turns three event sources into a readable status word, a shared interrupt request and a processor-reset request. The sources are an alarm-match pulse from a comparator elsewhere, one tick chosen by a 4-bit rate select from a bank of fifteen prescaled tick enables, and a power-fail sense level. Events are held in a small status register until the host reads it. A read clears the event bits. The power bit is not cleared by a read because it follows the sense input. A first-time-up bit is set by reset and marks the first read after power-up.

The interrupt output is a pull-down enable for an open-drain line. It is driven only while a cause is present and is released otherwise. The processor-reset output is gated by a software enable. It asserts when power fails or when a watchdog expires. The watchdog counts clock cycles and is restarted only by a chip-enable pulse during which the serial clock stayed still. A chip-enable pulse that carried a transfer does not restart it.

Top module: `irq_wdog_ctrl`

## Requirements
- R1: While `rst` is sampled high, `stat_q` becomes 4'b1000: first-time-up (bit 3) set, all other bits clear. `irq_pull` and `cpu_rst` are 0 one cycle later.
- R2: If `per_sel` is k in 1..15 and `tick_en[k-1]` is high at a clock edge, bit 0 (clock event) of `stat_q` is set after that edge. If `per_sel` is 0, no tick sets bit 0.
- R3: An `alarm_hit` high at a clock edge sets bit 1 (alarm event) of `stat_q` after that edge.
- R4: Bit 2 of `stat_q` equals `pwr_sense` as sampled at the previous edge. A read has no effect on it.
- R5: `stat_rd` high at an edge clears bits 0, 1 and 3 of `stat_q` after that edge, unless R6 applies.
- R6: An event arriving at the same edge as `stat_rd` leaves its bit set.
- R7: At each edge `irq_pull` is loaded with (bit0) OR (bit1 AND `alarm_ie`) OR (bit2 AND `pwr_ie`), using the `stat_q` value before that edge. When it is 0 the line is released.
- R8: With `wdog_en` high, a cycle counter restarts at 0 on a service and otherwise counts up, saturating at WDOG_LIMIT. One edge after the counter reaches WDOG_LIMIT, `cpu_rst` goes high if `cpur_en` is high.
- R9: A service is a high-to-low edge of `ce_mon` ending a high pulse during which `sck_mon` never changed level. A pulse with any `sck_mon` change does not service the watchdog.
- R10: `cpu_rst` is loaded each edge with `cpur_en` AND (watchdog expired OR `pwr_sense`). With `cpur_en` low it stays 0.
- R11: While `wdog_en` is low the counter is held at 0, so a full WDOG_LIMIT cycles must pass after enabling before expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| alarm_hit | input | 1 | Alarm-match pulse |
| tick_en | input | 15 | Prescaled tick enables, rate 1 at bit 0 |
| per_sel | input | 4 | Periodic rate select, 0 = off |
| pwr_sense | input | 1 | Power-fail sense level, high = failing |
| ce_mon | input | 1 | Chip-enable pin monitor |
| sck_mon | input | 1 | Serial-clock pin monitor |
| alarm_ie | input | 1 | Alarm interrupt enable |
| pwr_ie | input | 1 | Power-fail interrupt enable |
| wdog_en | input | 1 | Watchdog enable |
| cpur_en | input | 1 | Processor-reset output enable |
| stat_rd | input | 1 | Status-read strobe |
| stat_q | output | 4 | Status: 3 first-up, 2 power, 1 alarm, 0 clock |
| irq_pull | output | 1 | Interrupt line pull-down enable |
| cpu_rst | output | 1 | Processor-reset request, active high |

## Verification
The bench targets reads that coincide with a new event. A design that cleared unconditionally would lose that event and show the bit as 0. It steps the rate select through zero and several nonzero values while all ticks toggle, which catches an off-by-one in the tick mapping or a select of zero that still fires. Chip-enable pulses are sent both with and without serial-clock movement. A design that accepted the dirty pulse would hold off `cpu_rst` too long, and one that ignored clean pulses would raise it early. The bench also reads while power is failing, which exposes a power bit that wrongly clears on read.

// File: rtl/irq_wdog_pkg.sv
package irq_wdog_pkg;
  localparam int STAT_W = 4;

  typedef struct packed {
    logic first_up;
    logic pwr;
    logic alm;
    logic clk_ev;
  } stat_t;
endpackage

// File: rtl/periodic_sel.sv
module periodic_sel #(
  parameter int SEL_W = 4,
  localparam int N_RATES = (1 << SEL_W) - 1
) (
  input  logic [N_RATES-1:0] tick_en,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick
);
  logic [N_RATES-1:0] hit;

  for (genvar i = 0; i < N_RATES; i++) begin : g_rate
    assign hit[i] = (sel == SEL_W'(i + 1)) && tick_en[i];
  end

  assign tick = |hit;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_wdog_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  alarm_hit,
  input  logic  pwr_sense,
  input  logic  rd,
  output stat_t flags
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '{first_up: 1'b1, pwr: 1'b0, alm: 1'b0, clk_ev: 1'b0};
    end else begin
      flags.clk_ev   <= tick | (flags.clk_ev & ~rd);
      flags.alm      <= alarm_hit | (flags.alm & ~rd);
      flags.first_up <= flags.first_up & ~rd;
      flags.pwr      <= pwr_sense;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int LIMIT = 100,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ce,
  input  logic sck,
  output logic expired
);
  logic             ce_q, sck_q, dirty;
  logic [CNT_W-1:0] cnt;
  logic             service, sck_chg;

  assign sck_chg = sck ^ sck_q;
  assign service = ce_q & ~ce & ~dirty;
  assign expired = (cnt == CNT_W'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q  <= 1'b0;
      sck_q <= 1'b0;
      dirty <= 1'b0;
      cnt   <= '0;
    end else begin
      ce_q  <= ce;
      sck_q <= sck;
      if (ce && !ce_q)      dirty <= sck_chg;
      else if (ce && sck_chg) dirty <= 1'b1;
      if (!en || service)   cnt <= '0;
      else if (!expired)    cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/irq_wdog_ctrl.sv
module irq_wdog_ctrl
  import irq_wdog_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int WDOG_LIMIT = 100,
  localparam int N_RATES = (1 << SEL_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               alarm_hit,
  input  logic [N_RATES-1:0] tick_en,
  input  logic [SEL_W-1:0]   per_sel,
  input  logic               pwr_sense,
  input  logic               ce_mon,
  input  logic               sck_mon,
  input  logic               alarm_ie,
  input  logic               pwr_ie,
  input  logic               wdog_en,
  input  logic               cpur_en,
  input  logic               stat_rd,
  output logic [STAT_W-1:0]  stat_q,
  output logic               irq_pull,
  output logic               cpu_rst
);
  logic  tick, expired;
  stat_t flags;

  periodic_sel #(.SEL_W(SEL_W)) u_sel (
    .tick_en(tick_en), .sel(per_sel), .tick(tick)
  );

  irq_status_reg u_stat (
    .clk(clk), .rst(rst), .tick(tick), .alarm_hit(alarm_hit),
    .pwr_sense(pwr_sense), .rd(stat_rd), .flags(flags)
  );

  wdog_timer #(.LIMIT(WDOG_LIMIT)) u_wdog (
    .clk(clk), .rst(rst), .en(wdog_en), .ce(ce_mon), .sck(sck_mon),
    .expired(expired)
  );

  assign stat_q = flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pull <= 1'b0;
      cpu_rst  <= 1'b0;
    end else begin
      irq_pull <= flags.clk_ev | (flags.alm & alarm_ie) | (flags.pwr & pwr_ie);
      cpu_rst  <= cpur_en & (expired | pwr_sense);
    end
  end
endmodule

// File: rtl/irq_wdog_chk.sv
module irq_wdog_chk (
  input logic       clk,
  input logic       rst,
  input logic       alarm_hit,
  input logic [3:0] per_sel,
  input logic       pwr_sense,
  input logic       cpur_en,
  input logic       stat_rd,
  input logic [3:0] stat_q,
  input logic       irq_pull,
  input logic       cpu_rst
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (stat_q == 4'b1000));
  a_r2_sel_off: assert property (@(posedge clk) disable iff (rst)
    (per_sel == 4'd0 && !stat_q[0]) |=> !stat_q[0]);
  a_r3_alarm_set: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |=> stat_q[1]);
  a_r4_pwr_high: assert property (@(posedge clk) disable iff (rst)
    pwr_sense |=> stat_q[2]);
  a_r4_pwr_low: assert property (@(posedge clk) disable iff (rst)
    !pwr_sense |=> !stat_q[2]);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !alarm_hit) |=> !stat_q[1] && !stat_q[3]);
  a_r7_no_cause: assert property (@(posedge clk) disable iff (rst)
    (stat_q[2:0] == 3'b000) |=> !irq_pull);
  a_r10_gate: assert property (@(posedge clk) disable iff (rst)
    !cpur_en |=> !cpu_rst);
endmodule

bind irq_wdog_ctrl irq_wdog_chk u_chk (
  .clk(clk), .rst(rst), .alarm_hit(alarm_hit), .per_sel(per_sel),
  .pwr_sense(pwr_sense), .cpur_en(cpur_en), .stat_rd(stat_rd),
  .stat_q(stat_q), .irq_pull(irq_pull), .cpu_rst(cpu_rst)
);

// File: tb/test_irq_wdog_ctrl.sv
`timescale 1ns/1ps
module test_irq_wdog_ctrl;
  localparam int LIM = 100;

  logic clk = 0, rst = 1;
  logic alarm_hit = 0, pwr_sense = 0, ce_mon = 0, sck_mon = 0;
  logic alarm_ie = 0, pwr_ie = 0, wdog_en = 0, cpur_en = 0, stat_rd = 0;
  logic [14:0] tick_en = '0;
  logic [3:0]  per_sel = '0;
  logic [3:0]  stat_q;
  logic        irq_pull, cpu_rst;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  // reference model state
  bit m_clk, m_alm, m_pwr, m_ftu = 1, m_irq, m_rst, m_ceq, m_sckq, m_dirty;
  int m_cnt;

  irq_wdog_ctrl #(.SEL_W(4), .WDOG_LIMIT(LIM)) i_irq_wdog_ctrl (
    .clk(clk), .rst(rst), .alarm_hit(alarm_hit), .tick_en(tick_en),
    .per_sel(per_sel), .pwr_sense(pwr_sense), .ce_mon(ce_mon),
    .sck_mon(sck_mon), .alarm_ie(alarm_ie), .pwr_ie(pwr_ie),
    .wdog_en(wdog_en), .cpur_en(cpur_en), .stat_rd(stat_rd),
    .stat_q(stat_q), .irq_pull(irq_pull), .cpu_rst(cpu_rst)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    bit tick, svc;
    cyc++;
    if (rst) begin
      m_clk = 0; m_alm = 0; m_pwr = 0; m_ftu = 1; m_irq = 0; m_rst = 0;
      m_cnt = 0; m_ceq = 0; m_sckq = 0; m_dirty = 0;
    end else begin
      m_irq = m_clk | (m_alm & alarm_ie) | (m_pwr & pwr_ie);
      m_rst = cpur_en & ((m_cnt == LIM) | pwr_sense);
      tick = (per_sel != 0) && tick_en[per_sel - 1];
      m_clk = tick | (m_clk & !stat_rd);
      m_alm = alarm_hit | (m_alm & !stat_rd);
      m_ftu = m_ftu & !stat_rd;
      m_pwr = pwr_sense;
      svc = m_ceq && !ce_mon && !m_dirty;
      if (!wdog_en || svc) m_cnt = 0;
      else if (m_cnt < LIM) m_cnt++;
      if (ce_mon && !m_ceq) m_dirty = (sck_mon != m_sckq);
      else if (ce_mon && sck_mon != m_sckq) m_dirty = 1;
      m_ceq = ce_mon; m_sckq = sck_mon;
    end
    #2;
    if (!rst) begin
      chk("R2 clock bit", stat_q[0], m_clk);
      chk("R3 alarm bit", stat_q[1], m_alm);
      chk("R4 power bit", stat_q[2], m_pwr);
      chk("R5 first-up bit", stat_q[3], m_ftu);
      chk("R7 irq_pull", irq_pull, m_irq);
      chk("R8 cpu_rst", cpu_rst, m_rst);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ce_pulse(input bit with_sck);
    ce_mon = 1; step(1);
    if (with_sck) sck_mon = ~sck_mon;
    step(1);
    if (with_sck) sck_mon = ~sck_mon;
    step(1);
    ce_mon = 0; step(1);
  endtask

  initial begin
    step(3);
    rst = 0;
    step(1);
    chk("R1 reset status", stat_q, 4'b1000);
    chk("R1 reset irq", irq_pull, 0);
    chk("R1 reset cpu_rst", cpu_rst, 0);

    // R5: read clears first-up
    stat_rd = 1; step(1); stat_rd = 0; step(1);
    chk("R5 first-up cleared", stat_q[3], 0);

    // R2: select 0 ignores ticks, then several rates
    tick_en = '1; step(4);
    chk("R2 sel 0 no event", stat_q[0], 0);
    tick_en = '0;
    for (int k = 1; k <= 15; k += 4) begin
      per_sel = 4'(k);
      tick_en = 15'(1) << (k % 15); step(2);
      chk("R2 wrong tick ignored", stat_q[0], 0);
      tick_en = 15'(1) << (k - 1); step(1); tick_en = '0; step(1);
      chk("R2 selected tick", stat_q[0], 1);
      stat_rd = 1; step(1); stat_rd = 0; step(1);
    end
    per_sel = 0;

    // R3 + R7: alarm with and without enable
    alarm_hit = 1; step(1); alarm_hit = 0; step(2);
    chk("R7 alarm masked", irq_pull, 0);
    alarm_ie = 1; step(2);
    chk("R7 alarm irq", irq_pull, 1);

    // R6: event at same edge as read
    alarm_hit = 1; stat_rd = 1; step(1); alarm_hit = 0; stat_rd = 0; step(1);
    chk("R6 alarm kept on read", stat_q[1], 1);
    stat_rd = 1; step(1); stat_rd = 0; step(2);
    chk("R5 alarm cleared", stat_q[1], 0);
    chk("R7 irq released", irq_pull, 0);

    // R4: power bit survives reads; R10 power drives reset when enabled
    pwr_sense = 1; pwr_ie = 1; step(2);
    stat_rd = 1; step(1); stat_rd = 0; step(1);
    chk("R4 power bit held over read", stat_q[2], 1);
    chk("R10 cpur_en off", cpu_rst, 0);
    cpur_en = 1; step(2);
    chk("R10 power fail reset", cpu_rst, 1);
    pwr_sense = 0; step(3);
    chk("R4 power bit follows", stat_q[2], 0);
    chk("R10 reset drops", cpu_rst, 0);

    // R8/R9: clean services keep the watchdog quiet
    wdog_en = 1;
    for (int r = 0; r < 4; r++) begin step(60); ce_pulse(0); end
    chk("R9 clean service", cpu_rst, 0);
    // dirty pulse does not service
    step(40); ce_pulse(1); step(LIM - 40);
    chk("R9 dirty pulse ignored", cpu_rst, 1);
    ce_pulse(0); step(2);
    chk("R8 recovered after service", cpu_rst, 0);

    // R11: disable holds counter at zero
    wdog_en = 0; step(300); wdog_en = 1; step(LIM - 5);
    chk("R11 full window after enable", cpu_rst, 0);
    step(10);
    chk("R8 expiry", cpu_rst, 1);
    cpur_en = 0; step(2);
    chk("R10 gated off", cpu_rst, 0);
    step(5);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog timeout: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule